// File: doc/BRIEF.md
# Segmented Carry-Speculating Approximate Adder

This block adds two unsigned N-bit operands in a single combinational pass, but gives up part of the carry chain in exchange for a short critical path. The operands are cut into N/K equal slices of K bits. Each slice has two jobs. It predicts its own carry-out from its K operand bits alone, with a carry-in of zero. It also forms its K sum bits, using the predicted carry of the slice directly beneath it as its carry-in. The bottom slice adds with a carry-in of zero.

No carry can therefore travel further than two slices (2K bits). Inside a slice, carries are resolved by a parallel-prefix network, so the depth grows with log2(K). A carry that would ripple across a whole slice of propagate bits into a third slice is lost. The result then falls below the exact sum by a whole multiple of 2^K. The block suits datapaths that tolerate error, where most carry chains are short.

Top module: `approx_seg_adder`

## Requirements
- R1: The low K bits of `sum` always equal the low K bits of the exact sum `a+b`. Slice 0 adds `a[K-1:0]+b[K-1:0]` with a carry-in of zero. With both operands zero, the result is zero.
- R2: For slice j ≥ 1, covering bits jK..jK+K-1, the slice sum equals `(a_j + b_j + c_j) mod 2^K`. Here c_j is 1 exactly when `a_{j-1} + b_{j-1} >= 2^K`, with the slices taken as unsigned K-bit values.
- R3: `cout` is 1 exactly when `a_top + b_top + c_top >= 2^K`, where top is slice N/K-1 and c_top is as defined in R2.
- R4: When, at every slice boundary jK (j ≥ 1), the exact carry into bit jK equals the carry predicted from slice j-1 alone, `{cout,sum}` equals the exact (N+1)-bit sum.
- R5: `{cout,sum}` never exceeds the exact sum, and the exact sum minus `{cout,sum}` is a multiple of 2^K.
- R6: The outputs depend only on the present operands. Applying a given operand pair again, after a different pair, gives the same result.
- R7: A carry that has to cross two or more slice boundaries is dropped. With N=16 and K=4, 0x0FF0+0x0010 gives 0x0000 with cout 0, and 0xFFFF+0x0001 gives 0xFF00 with cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| sum | output | N | Approximate sum, low N bits |
| cout | output | 1 | Carry out of the top slice's sum |

## Verification
The embedded checks assume that N is a whole multiple of K and that both operands are fully driven, known values. They also assume they are evaluated once the combinational network has settled on a new operand pair. The bench meets these conditions in three ways. It drives only defined 16-bit values. It changes the operands just once per cycle, right after the rising edge. It compares results half a cycle later, on the falling edge. Its stimulus mixes directed patterns and random pairs, so that long carry chains are hit on purpose and also appear by chance among the random pairs.

// File: rtl/approx_seg_pkg.sv
// Package: approx_seg_pkg
// Shared default sizes for the segmented speculating adder.
// Assumes: the default width is a whole multiple of the default slice size.
package approx_seg_pkg;
    localparam int unsigned DEF_WIDTH = 16;
    localparam int unsigned DEF_SLICE = 4;
endpackage

// File: rtl/seg_prefix.sv
// Module: seg_prefix
// Parallel-prefix (Kogge-Stone style) group generate/propagate over K bits.
// grp_g[i] is the carry out of bit i for a zero carry-in at bit 0;
// grp_p[i] is 1 when bits 0..i all propagate. Depth is ceil(log2(K)) levels.
// Assumes: K >= 1.
module seg_prefix #(
    parameter int unsigned K = 4
) (
    input  logic [K-1:0] op_a,
    input  logic [K-1:0] op_b,
    output logic [K-1:0] bit_p,
    output logic [K-1:0] grp_g,
    output logic [K-1:0] grp_p
);
    localparam int unsigned LVLS = (K > 1) ? $clog2(K) : 0;

    logic [K-1:0] g_lvl [LVLS+1];
    logic [K-1:0] p_lvl [LVLS+1];

    // Purpose: bitwise generate/propagate and log-depth prefix combination.
    always_comb begin
        g_lvl[0] = op_a & op_b;
        p_lvl[0] = op_a ^ op_b;
        for (int l = 0; l < LVLS; l++) begin
            for (int i = 0; i < K; i++) begin
                if (i >= (1 << l)) begin
                    g_lvl[l+1][i] = g_lvl[l][i] | (p_lvl[l][i] & g_lvl[l][i-(1<<l)]);
                    p_lvl[l+1][i] = p_lvl[l][i] & p_lvl[l][i-(1<<l)];
                end else begin
                    g_lvl[l+1][i] = g_lvl[l][i];
                    p_lvl[l+1][i] = p_lvl[l][i];
                end
            end
        end
    end

    assign bit_p = p_lvl[0];
    assign grp_g = g_lvl[LVLS];
    assign grp_p = p_lvl[LVLS];
endmodule

// File: rtl/seg_slice.sv
// Module: seg_slice
// One K-bit slice: a carry predictor (own bits, zero carry-in) and a sum
// generator that takes its carry-in from the slice below.
// Assumes: spec_cin is the predicted carry of the next-lower slice (0 for slice 0).
module seg_slice #(
    parameter int unsigned K = 4
) (
    input  logic [K-1:0] op_a,
    input  logic [K-1:0] op_b,
    input  logic         spec_cin,
    output logic         pred_carry,
    output logic [K-1:0] part_sum,
    output logic         sum_carry
);
    logic [K-1:0] bp;
    logic [K-1:0] gg;
    logic [K-1:0] gp;
    logic [K:0]   carry_in_bit;

    seg_prefix #(.K(K)) i_prefix (
        .op_a  (op_a),
        .op_b  (op_b),
        .bit_p (bp),
        .grp_g (gg),
        .grp_p (gp)
    );

    // Purpose: carry into each bit from group terms plus the speculated carry-in.
    always_comb begin
        carry_in_bit[0] = spec_cin;
        for (int i = 1; i <= K; i++) begin
            carry_in_bit[i] = gg[i-1] | (gp[i-1] & spec_cin);
        end
    end

    assign pred_carry = gg[K-1];
    assign part_sum   = bp ^ carry_in_bit[K-1:0];
    assign sum_carry  = carry_in_bit[K];
endmodule

// File: rtl/approx_seg_adder.sv
// Module: approx_seg_adder
// Combinational N-bit approximate adder built from N/K carry-speculating slices.
// Each slice's sum uses the predicted carry of the slice below only, so no
// carry path is longer than 2K bits. cout is the top slice's sum carry.
// Assumes: N is a whole multiple of K; inputs are settled, known values.
module approx_seg_adder #(
    parameter int unsigned N = approx_seg_pkg::DEF_WIDTH,
    parameter int unsigned K = approx_seg_pkg::DEF_SLICE
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int unsigned SEGS = N / K;

    logic [SEGS-1:0] pred_c;
    logic [SEGS-1:0] top_c;
    logic [SEGS-1:0] spec_in;

    genvar j;
    generate
        for (j = 0; j < SEGS; j++) begin : g_slice
            if (j == 0) begin : g_base
                assign spec_in[j] = 1'b0;
            end else begin : g_upper
                assign spec_in[j] = pred_c[j-1];
            end
            seg_slice #(.K(K)) i_slice (
                .op_a       (a[j*K +: K]),
                .op_b       (b[j*K +: K]),
                .spec_cin   (spec_in[j]),
                .pred_carry (pred_c[j]),
                .part_sum   (sum[j*K +: K]),
                .sum_carry  (top_c[j])
            );
        end
    endgenerate

    assign cout = top_c[SEGS-1];

    // ---------------- embedded checks ----------------
    logic [N:0] ref_sum;
    logic [N:0] got_sum;
    logic [N:0] shortfall;
    logic       long_chain;

    // Purpose: exact reference and detection of a boundary whose true carry was mispredicted.
    always_comb begin
        ref_sum    = {1'b0, a} + {1'b0, b};
        got_sum    = {cout, sum};
        shortfall  = ref_sum - got_sum;
        long_chain = 1'b0;
        for (int s = 1; s < SEGS; s++) begin
            if ((ref_sum[s*K] ^ a[s*K] ^ b[s*K]) != pred_c[s-1]) begin
                long_chain = 1'b1;
            end
        end
    end

    // Purpose: guard the adder's error bounds against the exact sum.
    always_comb begin
        assert_low_slice_exact_R1: assert (sum[K-1:0] == ref_sum[K-1:0])
            else $error("low slice differs from exact sum");
        assert_exact_if_short_R4: assert (long_chain || (got_sum == ref_sum))
            else $error("mismatch without a long carry chain");
        assert_never_above_R5: assert (got_sum <= ref_sum)
            else $error("approximate result above exact sum");
        assert_whole_slices_R5: assert (shortfall[K-1:0] == '0)
            else $error("shortfall not a multiple of slice weight");
    end
endmodule

// File: tb/test_approx_seg_adder.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver pushes expected items; the monitor pops and compares.
module test_approx_seg_adder;
    localparam int unsigned N    = 16;
    localparam int unsigned K    = 4;
    localparam int unsigned SEGS = N / K;
    localparam longint unsigned MASK = (64'd1 << K) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [N-1:0] sum;
    logic         cout;

    int total = 0;
    int bad = 0;
    int mism = 0;
    bit reported = 0;

    typedef struct {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N:0]   expv;
        logic [N:0]   exact;
        bit           longc;
        string        tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    approx_seg_adder #(.N(N), .K(K)) i_approx_seg_adder (
        .a(a), .b(b), .sum(sum), .cout(cout)
    );

    // Model from R1-style slice rules (R2, R3).
    function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] y);
        longint unsigned res = 0;
        for (int j = 0; j < SEGS; j++) begin
            longint unsigned xj = (longint'(x) >> (j*K)) & MASK;
            longint unsigned yj = (longint'(y) >> (j*K)) & MASK;
            longint unsigned c  = 0;
            longint unsigned s;
            if (j > 0) begin
                c = ((((longint'(x) >> ((j-1)*K)) & MASK) +
                      ((longint'(y) >> ((j-1)*K)) & MASK)) >> K) & 1;
            end
            s = xj + yj + c;
            res = res | ((s & MASK) << (j*K));
            if (j == SEGS-1) res = res | (((s >> K) & 1) << N);
        end
        return res[N:0];
    endfunction

    // True when some boundary's exact carry differs from the one-slice prediction.
    function automatic bit chain_too_long(input logic [N-1:0] x, input logic [N-1:0] y);
        for (int j = 1; j < SEGS; j++) begin
            longint unsigned lm = (64'd1 << (j*K)) - 1;
            longint unsigned ec = (((longint'(x) & lm) + (longint'(y) & lm)) >> (j*K)) & 1;
            longint unsigned gc = ((((longint'(x) >> ((j-1)*K)) & MASK) +
                                    ((longint'(y) >> ((j-1)*K)) & MASK)) >> K) & 1;
            if (ec != gc) return 1;
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N:0] act, input logic [N:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
        item_t it;
        @(posedge clk);
        a = x;
        b = y;
        it.a = x;
        it.b = y;
        it.expv = model(x, y);
        it.exact = {1'b0, x} + {1'b0, y};
        it.longc = chain_too_long(x, y);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compares each settled result half a cycle after it was driven.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [N:0] got;
                it = sb_q.pop_front();
                got = {cout, sum};
                check(got == it.expv, it.tag, got, it.expv);
                check(got <= it.exact, "R5 not above exact", got, it.exact);
                if (got != it.exact) begin
                    mism++;
                    check(it.longc, "R4 mismatch only on long chain", got, it.exact);
                end else begin
                    check(1'b1, "R4 exact", got, it.exact);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({cout, sum} == '0, "R1 reset state zero", {cout, sum}, '0);
        @(posedge clk);
        rst_n = 1'b1;
        drive(16'h0000, 16'h0000, "R1 zeros");
        drive(16'h0009, 16'h0008, "R1 low slice carry");
        drive(16'h000F, 16'h0001, "R2 carry into slice 1");
        drive(16'h00F0, 16'h0010, "R2 two-slice chain");
        drive(16'h1234, 16'h4321, "R2 no carries");
        drive(16'hF000, 16'h1000, "R3 cout from top slice");
        drive(16'hFFFF, 16'hFFFF, "R3 all ones");
        drive(16'h0FF0, 16'h0010, "R7 three-slice chain dropped");
        drive(16'hFFFF, 16'h0001, "R7 full chain dropped");
        drive(16'h0FF0, 16'h0010, "R6 repeat A");
        drive(16'h5555, 16'h2222, "R6 other");
        drive(16'h0FF0, 16'h0010, "R6 repeat A again");
        for (int i = 0; i < 600; i++) begin
            drive(N'($urandom), N'($urandom), "R2 random");
        end
        repeat (3) @(negedge clk);
        total++;
        if (mism == 0) begin
            bad++;
            $display("FAIL R7 no dropped carries seen: actual=%0d expected=>0", mism);
        end
        report();
    end
endmodule